// File: doc/BRIEF.md
# Sign-Based Fixed-Step Weight Updater

This block is the learning element that sits beside one synapse of a network trained by equilibrium propagation. Two copies of the network settle at the same time: one runs unclamped, and the other has its outputs pushed toward the target. The block receives one signed sample of the voltage across the synapse from each copy. It reduces both samples to magnitudes and compares them. From that comparison it chooses a single fixed-size step for the stored weight. The step goes down when the nudged magnitude is the larger one, and up otherwise. No free-phase value is ever stored, and the step size never depends on the size of the error.

The work alternates between two halves. In the sensing half the synapse is attached to the network. The block accepts a sample pair and records its decision. In the programming half the synapse is detached from the network. The block then drives at most one increment or decrement pulse, and the weight code moves one count, clamped at both ends. The sample pair enters through a valid/ready handshake. Ready is high only in sensing cycles. A pair is taken only in a cycle where both valid and ready are high. When no pair is taken in a sensing cycle, the programming cycle that follows issues no pulse. Nothing is buffered, so a source that holds valid high across a programming cycle simply waits for the next sensing cycle.

Top module: `syn_step_updater`

## Requirements
- R1: Each sample is reduced to its magnitude before the comparison. A negative sample is replaced by its negation, so a free sample of -9 and a nudged sample of +5 give an increment.
- R2: When the nudged magnitude is strictly larger than the free magnitude, the programming cycle raises `dec_pulse` and the weight code drops by one.
- R3: When the two magnitudes are equal, or the nudged magnitude is smaller, the programming cycle raises `inc_pulse` and the weight code rises by one.
- R4: The most negative sample value (sign bit 1, all other bits 0) takes the largest positive magnitude, 2^(SAMPLE_W-1)-1, and does not wrap.
- R5: No pulse is ever high in a cycle where `sample_ready` is high, that is, in a sensing cycle.
- R6: The weight code saturates at 0 and at 2^WEIGHT_BITS-1. A pulse toward a bound the code already holds is still issued, but it leaves the code unchanged.
- R7: While `enable` is low in a programming cycle, no pulse is issued and the weight holds.
- R8: Synchronous reset sets the weight to mid-scale, 2^(WEIGHT_BITS-1). It clears the held decision and starts in a sensing cycle, with `sample_ready` high and both pulses low.
- R9: `sample_ready` alternates every cycle, high for sensing and low for programming. A sensing cycle without `sample_valid` produces no pulse in the programming cycle that follows.
- R10: `inc_pulse` and `dec_pulse` are never high together. Each lasts one cycle, and the weight changes by exactly one count at the end of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one half of the sense/program pair |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Allows programming pulses |
| sample_valid | input | 1 | Sample pair is present |
| sample_ready | output | 1 | High in sensing cycles; the pair is taken when valid and ready are both high |
| free_sample | input | SAMPLE_W | Signed two's-complement sample from the unclamped copy |
| nudge_sample | input | SAMPLE_W | Signed two's-complement sample from the target-clamped copy |
| inc_pulse | output | 1 | Increase-weight programming pulse |
| dec_pulse | output | 1 | Decrease-weight programming pulse |
| weight | output | WEIGHT_BITS | Unsigned weight code; 0 is the minimum conductance |

## Verification
Two functions can land in the same programming cycle: a pulse is issued while the weight clamps against the bound it already holds. A long run of pulses in one direction drives the code onto each bound and then keeps pushing. The judge is that the pulse is still seen while the code stays put. The other collision is a decision that is being held while `enable` drops or while no pair was accepted in the sensing cycle. That is provoked by lowering `enable` or `valid` during the pair, and it is judged by the absence of both pulses and an unchanged weight.

// File: rtl/syn_upd_pkg.sv
package syn_upd_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } step_dir_e;

  typedef struct packed {
    logic      armed;
    step_dir_e dir;
  } decision_t;
endpackage

// File: rtl/syn_mag_conv.sv
module syn_mag_conv #(
  parameter int SAMPLE_W = 8
) (
  input  logic [SAMPLE_W-1:0] smp,
  output logic [SAMPLE_W-2:0] mag
);
  localparam logic [SAMPLE_W-2:0] MAG_TOP = '1;

  logic                is_neg;
  logic                is_floor;
  logic [SAMPLE_W-1:0] negated;

  always_comb begin
    is_neg   = smp[SAMPLE_W-1];
    is_floor = is_neg && (smp[SAMPLE_W-2:0] == '0);
    negated  = ~smp + 1'b1;
    if (!is_neg)       mag = smp[SAMPLE_W-2:0];
    else if (is_floor) mag = MAG_TOP;
    else               mag = negated[SAMPLE_W-2:0];
  end
endmodule

// File: rtl/syn_decide.sv
module syn_decide
  import syn_upd_pkg::*;
#(
  parameter int MAG_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sensing,
  input  logic             take,
  input  logic [MAG_W-1:0] free_mag,
  input  logic [MAG_W-1:0] nudge_mag,
  output decision_t        held
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '{armed: 1'b0, dir: DIR_UP};
    end else if (sensing) begin
      held.armed <= take;
      held.dir   <= (nudge_mag > free_mag) ? DIR_DOWN : DIR_UP;
    end
  end

  AST_DOWN_WHEN_NUDGE_LARGER: assert property (@(posedge clk) disable iff (rst)
    (sensing && take && (nudge_mag > free_mag)) |=> (held.armed && held.dir == DIR_DOWN)); // R2
  AST_UP_WHEN_NOT_LARGER: assert property (@(posedge clk) disable iff (rst)
    (sensing && take && (nudge_mag <= free_mag)) |=> (held.armed && held.dir == DIR_UP)); // R3
  AST_NO_TAKE_NO_ARM: assert property (@(posedge clk) disable iff (rst)
    (sensing && !take) |=> !held.armed); // R9
endmodule

// File: rtl/syn_pulse_drv.sv
module syn_pulse_drv
  import syn_upd_pkg::*;
(
  input  logic      programming,
  input  logic      enable,
  input  decision_t held,
  output logic      inc_pulse,
  output logic      dec_pulse
);
  logic fire;

  always_comb begin
    fire      = programming && enable && held.armed;
    inc_pulse = fire && (held.dir == DIR_UP);
    dec_pulse = fire && (held.dir == DIR_DOWN);
  end
endmodule

// File: rtl/syn_weight_reg.sv
module syn_weight_reg #(
  parameter int WEIGHT_BITS = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   inc,
  input  logic                   dec,
  output logic [WEIGHT_BITS-1:0] weight
);
  localparam logic [WEIGHT_BITS-1:0] W_TOP = '1;
  localparam logic [WEIGHT_BITS-1:0] W_MID = WEIGHT_BITS'(1) << (WEIGHT_BITS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      weight <= W_MID;
    end else if (inc && !dec && weight != W_TOP) begin
      weight <= weight + 1'b1;
    end else if (dec && !inc && weight != '0) begin
      weight <= weight - 1'b1;
    end
  end

  AST_UP_ONE: assert property (@(posedge clk) disable iff (rst)
    (inc && weight != W_TOP) |=> (weight == $past(weight) + 1'b1)); // R10
  AST_DOWN_ONE: assert property (@(posedge clk) disable iff (rst)
    (dec && weight != '0) |=> (weight == $past(weight) - 1'b1)); // R10
  AST_CLAMP_TOP: assert property (@(posedge clk) disable iff (rst)
    (inc && weight == W_TOP) |=> (weight == W_TOP)); // R6
  AST_CLAMP_BOTTOM: assert property (@(posedge clk) disable iff (rst)
    (dec && weight == '0) |=> (weight == '0)); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!inc && !dec) |=> $stable(weight)); // R7
endmodule

// File: rtl/syn_step_updater.sv
module syn_step_updater
  import syn_upd_pkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int WEIGHT_BITS = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   enable,
  input  logic                   sample_valid,
  output logic                   sample_ready,
  input  logic [SAMPLE_W-1:0]    free_sample,
  input  logic [SAMPLE_W-1:0]    nudge_sample,
  output logic                   inc_pulse,
  output logic                   dec_pulse,
  output logic [WEIGHT_BITS-1:0] weight
);
  localparam int MAG_W   = SAMPLE_W - 1;
  localparam int N_COPIES = 2;

  logic                        prog_half;
  logic [SAMPLE_W-1:0]         smp_vec [N_COPIES];
  logic [MAG_W-1:0]            mag_vec [N_COPIES];
  decision_t                   held;

  always_ff @(posedge clk) begin
    if (rst) prog_half <= 1'b0;
    else     prog_half <= ~prog_half;
  end

  assign sample_ready = ~prog_half;
  assign smp_vec[0]   = free_sample;
  assign smp_vec[1]   = nudge_sample;

  for (genvar g = 0; g < N_COPIES; g++) begin : g_mag
    syn_mag_conv #(.SAMPLE_W(SAMPLE_W)) i_mag (
      .smp (smp_vec[g]),
      .mag (mag_vec[g])
    );
  end

  syn_decide #(.MAG_W(MAG_W)) i_decide (
    .clk       (clk),
    .rst       (rst),
    .sensing   (sample_ready),
    .take      (sample_valid && sample_ready),
    .free_mag  (mag_vec[0]),
    .nudge_mag (mag_vec[1]),
    .held      (held)
  );

  syn_pulse_drv i_drv (
    .programming (prog_half),
    .enable      (enable),
    .held        (held),
    .inc_pulse   (inc_pulse),
    .dec_pulse   (dec_pulse)
  );

  syn_weight_reg #(.WEIGHT_BITS(WEIGHT_BITS)) i_wreg (
    .clk    (clk),
    .rst    (rst),
    .inc    (inc_pulse),
    .dec    (dec_pulse),
    .weight (weight)
  );

  AST_NO_PULSE_SENSING: assert property (@(posedge clk) disable iff (rst)
    sample_ready |-> (!inc_pulse && !dec_pulse)); // R5
  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(inc_pulse && dec_pulse)); // R10
  AST_HALVES_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sample_ready != $past(sample_ready))); // R9
  AST_GATED_BY_ENABLE: assert property (@(posedge clk) disable iff (rst)
    !enable |-> (!inc_pulse && !dec_pulse)); // R7
endmodule

// File: tb/test_syn_step_updater.sv
module test_syn_step_updater;
  localparam int SW = 5;
  localparam int WB = 4;
  localparam int WTOP = (1 << WB) - 1;
  localparam int WMID = 1 << (WB - 1);
  localparam int SMIN = -(1 << (SW - 1));
  localparam int SMAX = (1 << (SW - 1)) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic          sample_valid = 1'b0;
  logic          sample_ready;
  logic [SW-1:0] free_sample = '0;
  logic [SW-1:0] nudge_sample = '0;
  logic          inc_pulse;
  logic          dec_pulse;
  logic [WB-1:0] weight;

  int checks = 0;
  int errors = 0;
  int model_w = WMID;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  syn_step_updater #(.SAMPLE_W(SW), .WEIGHT_BITS(WB)) i_syn_step_updater (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .sample_valid (sample_valid),
    .sample_ready (sample_ready),
    .free_sample  (free_sample),
    .nudge_sample (nudge_sample),
    .inc_pulse    (inc_pulse),
    .dec_pulse    (dec_pulse),
    .weight       (weight)
  );

  function automatic int mag_of(input int x);
    if (x >= 0) return x;
    if (x == SMIN) return SMAX;
    return -x;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Entry and exit: 2 ns after a rising edge, in a sensing cycle.
  task automatic pair(input int f, input int n, input bit v, input bit e, input string req);
    bit down;
    bit exp_inc;
    bit exp_dec;
    down    = mag_of(n) > mag_of(f);
    exp_inc = v && e && !down;
    exp_dec = v && e && down;
    check(sample_ready == 1'b1, "R9", int'(sample_ready), 1);
    free_sample  = SW'(f);
    nudge_sample = SW'(n);
    sample_valid = v;
    enable       = e;
    #1;
    check(!inc_pulse && !dec_pulse, "R5", int'({inc_pulse, dec_pulse}), 0);
    @(posedge clk); #2;
    check(sample_ready == 1'b0, "R9", int'(sample_ready), 0);
    check(!(inc_pulse && dec_pulse), "R10", int'({inc_pulse, dec_pulse}), int'({exp_inc, exp_dec}));
    check(inc_pulse == exp_inc && dec_pulse == exp_dec, req,
          int'({inc_pulse, dec_pulse}), int'({exp_inc, exp_dec}));
    sample_valid = 1'b0;
    if (exp_inc && model_w < WTOP) model_w++;
    if (exp_dec && model_w > 0) model_w--;
    @(posedge clk); #2;
    check(int'(weight) == model_w, req, int'(weight), model_w);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    string tag;
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    // R8: state right after reset
    check(int'(weight) == WMID, "R8", int'(weight), WMID);
    check(sample_ready == 1'b1, "R8", int'(sample_ready), 1);
    check(!inc_pulse && !dec_pulse, "R8", int'({inc_pulse, dec_pulse}), 0);

    // R1: negative samples compared by magnitude
    pair(-9, 5, 1'b1, 1'b1, "R1");
    pair(3, -7, 1'b1, 1'b1, "R1");
    pair(-6, -6, 1'b1, 1'b1, "R3");
    // R4: most negative value saturates to the largest magnitude
    pair(SMIN, SMAX, 1'b1, 1'b1, "R4");
    pair(SMAX, SMIN, 1'b1, 1'b1, "R4");
    pair(SMIN, SMIN + 1, 1'b1, 1'b1, "R4");

    // R6: drive down onto the bottom bound and keep pushing
    for (int k = 0; k < WTOP + 4; k++) pair(0, 5, 1'b1, 1'b1, "R6");
    check(int'(weight) == 0, "R6", int'(weight), 0);
    // R6: drive up onto the top bound and keep pushing
    for (int k = 0; k < WTOP + 4; k++) pair(5, 0, 1'b1, 1'b1, "R6");
    check(int'(weight) == WTOP, "R6", int'(weight), WTOP);

    // R7: enable low blocks pulses in either direction
    pair(0, 5, 1'b1, 1'b0, "R7");
    pair(0, 5, 1'b1, 1'b0, "R7");
    pair(5, 0, 1'b1, 1'b0, "R7");
    // R9: no accepted pair means no pulse
    pair(0, 5, 1'b0, 1'b1, "R9");
    pair(5, 0, 1'b0, 1'b1, "R9");

    // R2 / R3: exhaustive sweep of all sample pairs
    for (int f = SMIN; f <= SMAX; f++) begin
      for (int n = SMIN; n <= SMAX; n++) begin
        if (f == SMIN || n == SMIN)          tag = "R4";
        else if (mag_of(n) > mag_of(f))      tag = "R2";
        else if (mag_of(n) == mag_of(f))     tag = "R3";
        else if (f < 0 || n < 0)             tag = "R1";
        else                                 tag = "R3";
        pair(f, n, 1'b1, 1'b1, tag);
      end
    end

    // R8: reset in the middle of a run
    pair(0, 5, 1'b1, 1'b1, "R2");
    rst = 1'b1;
    @(posedge clk); #2;
    rst = 1'b0;
    model_w = WMID;
    check(int'(weight) == WMID, "R8", int'(weight), WMID);
    check(sample_ready == 1'b1, "R8", int'(sample_ready), 1);
    pair(0, 0, 1'b0, 1'b1, "R8");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule